// File: doc/BRIEF.md
# PPS-Aligned PLL Sync Pulse Generator

This block issues a single-cycle SYNC pulse to an external clock-synthesizer PLL. The pulse is aligned to a pulse-per-second (PPS) reference. Software raises a level-sensitive arm input. The block then waits for the next rising edge of PPS. From that edge it counts a fixed two-cycle latency plus a programmable 8-bit extra delay, and then fires SYNC.

Completion is reported on a status line that stays high while arm remains asserted. Software clears the status by lowering arm, and that same action re-arms the block for a later sequence. PPS is asynchronous to the block clock and passes through a synchronizer chain of parameterised depth.

Top module: `pps_pll_sync_gen`

## Requirements
- R1: While `rst` is high, and on the edge after it, `pll_sync` and `sync_done` are low and the block is idle.
- R2: With `arm` low, PPS rising edges produce no `pll_sync` pulse.
- R3: With `extra_delay` = 0, `pll_sync` rises on the clock edge SYNC_STAGES+1 edges after the first edge that samples `pps_in` high. With the default SYNC_STAGES = 2 that is 3 edges, which is two cycles after the synchronized PPS edge.
- R4: A non-zero `extra_delay` value D adds D cycles to the R3 latency. D = 3 gives 6 edges and D = 255 gives 258 edges with the default depth.
- R5: `extra_delay` is captured on the edge that detects the PPS rise. Later changes to it do not alter the pulse timing.
- R6: `pll_sync` is high for exactly one clock cycle.
- R7: `sync_done` rises on the same edge as `pll_sync` and stays high while `arm` stays high.
- R8: `sync_done` falls on the edge that samples `arm` low.
- R9: While `arm` stays high after completion, further PPS edges produce no pulse. A new sequence needs `arm` to go low first.
- R10: If `arm` is lowered before the PPS edge, or during the delay count, no pulse is produced and `sync_done` stays low.
- R11: Only a PPS rise that happens after arming counts. A PPS that is already high when `arm` rises does not fire; its next rising edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pps_in | input | 1 | Asynchronous pulse-per-second reference |
| arm | input | 1 | Level request; raise to start, lower to clear done and re-arm |
| extra_delay | input | DELAY_W | Extra cycles added after the fixed latency |
| pll_sync | output | 1 | One-cycle SYNC pulse to the PLL |
| sync_done | output | 1 | High from the pulse until arm is lowered |

## Verification
The assertions assume that `arm` is a slow software level, held for many cycles once it changes, and that `pps_in` stays high or low for several clock cycles at a time. Under these conditions every edge passes through the synchronizer cleanly. The stimulus drives every input on the falling clock edge and holds PPS levels for at least three cycles. It spaces each PPS edge well apart from the arm transitions. Where a test needs a PPS edge to race the arm input, it is placed a full cycle away so that the expected outcome is defined.

// File: rtl/pps_sync_pkg.sv
package pps_sync_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_COUNT = 2'd2,
      ST_DONE  = 2'd3
   } sync_state_t;

   // fixed cycles from synchronized PPS edge to SYNC with zero extra delay
   localparam int unsigned FIXED_LATENCY = 2;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("pps_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= chain_q[LAST];
   end

   assign rise_o = chain_q[LAST] & ~prev_q;
endmodule

// File: rtl/sync_delay_counter.sv
module sync_delay_counter #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   input  logic             run,
   output logic             expired_o
);
   if (WIDTH < 1) begin : g_bad_width
      $error("sync_delay_counter: WIDTH must be positive");
   end

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                       cnt_q <= '0;
      else if (load)                 cnt_q <= load_val;
      else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/pps_sync_ctrl.sv
module pps_sync_ctrl
   import pps_sync_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic pps_rise,
   input  logic expired,
   output logic load_o,
   output logic run_o,
   output logic sync_o,
   output logic done_o
);
   sync_state_t state_q;
   logic        sync_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         sync_q  <= 1'b0;
      end else begin
         sync_q <= 1'b0;
         unique case (state_q)
            ST_IDLE:  if (arm) state_q <= ST_ARMED;
            ST_ARMED: begin
               if (!arm)          state_q <= ST_IDLE;
               else if (pps_rise) state_q <= ST_COUNT;
            end
            ST_COUNT: begin
               if (!arm) state_q <= ST_IDLE;
               else if (expired) begin
                  sync_q  <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            ST_DONE:  if (!arm) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign load_o = (state_q == ST_ARMED) && arm && pps_rise;
   assign run_o  = (state_q == ST_COUNT);
   assign sync_o = sync_q;
   assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/pps_pll_sync_gen.sv
module pps_pll_sync_gen #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DELAY_W     = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pps_in,
   input  logic               arm,
   input  logic [DELAY_W-1:0] extra_delay,
   output logic               pll_sync,
   output logic               sync_done
);
   logic pps_rise;
   logic cnt_load;
   logic cnt_run;
   logic cnt_expired;

   pps_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst      (rst),
      .async_in (pps_in),
      .rise_o   (pps_rise)
   );

   sync_delay_counter #(.WIDTH(DELAY_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .load      (cnt_load),
      .load_val  (extra_delay),
      .run       (cnt_run),
      .expired_o (cnt_expired)
   );

   pps_sync_ctrl u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .arm      (arm),
      .pps_rise (pps_rise),
      .expired  (cnt_expired),
      .load_o   (cnt_load),
      .run_o    (cnt_run),
      .sync_o   (pll_sync),
      .done_o   (sync_done)
   );
endmodule

// File: rtl/pps_pll_sync_gen_chk.sv
module pps_pll_sync_gen_chk (
   input logic clk,
   input logic rst,
   input logic arm,
   input logic pll_sync,
   input logic sync_done
);
   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!pll_sync && !sync_done));

   // R6
   one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      pll_sync |=> !pll_sync);

   // R7
   done_with_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      pll_sync |-> sync_done);

   // R8
   done_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_done && !arm) |=> !sync_done);

   // R9
   no_repeat_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      $past(sync_done) |-> !pll_sync);

   // R10
   pulse_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
      pll_sync |-> $past(arm));
endmodule

bind pps_pll_sync_gen pps_pll_sync_gen_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .arm       (arm),
   .pll_sync  (pll_sync),
   .sync_done (sync_done)
);

// File: tb/pps_pll_sync_gen_bench.sv
module pps_pll_sync_gen_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pps_in = 1'b0;
   logic       arm = 1'b0;
   logic [7:0] extra_delay = 8'd0;
   logic       pll_sync;
   logic       sync_done;

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit finished = 0;
   int exp_q[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   pps_pll_sync_gen u_pps_pll_sync_gen (
      .clk(clk), .rst(rst), .pps_in(pps_in), .arm(arm),
      .extra_delay(extra_delay), .pll_sync(pll_sync), .sync_done(sync_done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: raise PPS, push expected pulse cycle if one is due
   task automatic pps_edge(input bit expect_pulse, input int d);
      @(negedge clk);
      pps_in = 1'b1;
      if (expect_pulse) exp_q.push_back(cyc + 4 + d);
   endtask

   task automatic pps_low();
      @(negedge clk);
      pps_in = 1'b0;
   endtask

   // monitor: pops expected cycles and compares; R6 width check
   logic prev_sync = 1'b0;
   always @(negedge clk) begin
      if (!rst) begin
         if (pll_sync) begin
            pulses++;
            if (exp_q.size() == 0) check(1'b0, "R2/R9/R10 unexpected pulse", cyc, -1);
            else begin
               int e;
               e = exp_q.pop_front();
               check(cyc == e, "R3/R4/R5 pulse cycle", cyc, e);
            end
            check(!prev_sync, "R6 pulse width", prev_sync, 0);
         end
         prev_sync = pll_sync;
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      finish_run();
   end

   initial begin
      int p;
      wait_cyc(3);
      // R1
      check(pll_sync == 0 && sync_done == 0, "R1 reset outputs", {pll_sync, sync_done}, 0);
      rst = 1'b0;
      wait_cyc(3);

      // R2: PPS with arm low
      p = pulses;
      pps_edge(0, 0); wait_cyc(5); pps_low(); wait_cyc(10);
      check(pulses == p, "R2 no pulse unarmed", pulses, p);

      // R3: delay 0
      extra_delay = 8'd0; arm = 1'b1; wait_cyc(4);
      pps_edge(1, 0); wait_cyc(6); pps_low(); wait_cyc(4);
      check(sync_done == 1, "R7 done held", sync_done, 1);
      // R9: further PPS while still armed
      p = pulses;
      pps_edge(0, 0); wait_cyc(6); pps_low(); wait_cyc(6);
      check(pulses == p, "R9 no repeat", pulses, p);
      check(sync_done == 1, "R7 done still high", sync_done, 1);
      // R8
      arm = 1'b0; wait_cyc(1);
      check(sync_done == 0, "R8 done clears", sync_done, 0);
      wait_cyc(4);

      // R4: delay 3
      extra_delay = 8'd3; arm = 1'b1; wait_cyc(4);
      pps_edge(1, 3); wait_cyc(12); pps_low(); wait_cyc(2);
      arm = 1'b0; wait_cyc(4);

      // R4: delay 255
      extra_delay = 8'd255; arm = 1'b1; wait_cyc(4);
      pps_edge(1, 255); wait_cyc(5); pps_low(); wait_cyc(270);
      check(sync_done == 1, "R4 done after long delay", sync_done, 1);
      arm = 1'b0; wait_cyc(4);

      // R5: delay changed after detection
      extra_delay = 8'd10; arm = 1'b1; wait_cyc(4);
      pps_edge(1, 10); wait_cyc(4); extra_delay = 8'd0;
      pps_low(); wait_cyc(20);
      arm = 1'b0; wait_cyc(4);

      // R10: arm dropped before PPS
      p = pulses;
      arm = 1'b1; wait_cyc(4); arm = 1'b0; wait_cyc(3);
      pps_edge(0, 0); wait_cyc(5); pps_low(); wait_cyc(10);
      check(pulses == p && sync_done == 0, "R10 drop before pps", pulses, p);

      // R10: arm dropped during count
      extra_delay = 8'd50; arm = 1'b1; wait_cyc(4);
      pps_edge(0, 0); wait_cyc(10); arm = 1'b0; pps_low(); wait_cyc(60);
      check(pulses == p, "R10 drop during count", pulses, p);
      check(sync_done == 0, "R10 done low", sync_done, 0);

      // R11: PPS already high when arming
      extra_delay = 8'd1;
      pps_edge(0, 0); wait_cyc(5);
      arm = 1'b1; wait_cyc(6);
      check(pulses == p, "R11 level ignored", pulses, p);
      pps_low(); wait_cyc(3);
      pps_edge(1, 1); wait_cyc(8); pps_low(); wait_cyc(4);
      check(pulses == p + 1, "R11 next edge fires", pulses, p + 1);
      arm = 1'b0; wait_cyc(4);

      check(exp_q.size() == 0, "R3/R4 all expected pulses seen", exp_q.size(), 0);
      finish_run();
   end
endmodule